// File: doc/BRIEF.md
# Macro-Pixel Freeze and Timestamp Controller

This block sits between the pixel array of a tracking sensor and its readout chain. Pixels are grouped into macro pixels (MPs) of 2 x 8. Each MP keeps sixteen sticky hit flags, one per pixel, and reports a fast-OR of them. A periodic bunch-crossing tick drives an 8-bit time counter. At each tick, every MP that holds hits is frozen and tagged with the current count. A frozen MP takes no new hits until a scanner has read it, so each group of hits belongs to exactly one time slot.

Timestamps that have frozen MPs wait in a four-entry scan buffer, oldest first. For each pending timestamp the controller first emits a header word carrying the timestamp. It then accepts reads from an external scanner, which picks frozen MPs by index. Each accepted read returns the MP's pattern and releases the MP. When the last MP of that timestamp has been released, the entry is retired and the next one is served. The output stream is therefore sorted by time, with each timestamp word ahead of its patterns.

The controller runs as a four-state machine. ST_IDLE waits for a pending entry and moves to ST_HEADER once one exists. ST_HEADER emits the header for one cycle and always moves on to ST_SCAN. ST_SCAN accepts reads and moves to ST_RETIRE once no MP tagged with the head timestamp remains frozen. ST_RETIRE drops the head entry and returns to ST_IDLE.

Top module: `mp_freeze_ctrl`

## Requirements
- R1: `fastor_o[m]` is high exactly when MP m holds at least one hit flag. A pulse on `hit_i[m*16+p]` sets flag p of MP m, and that flag is visible from the cycle after the pulse.
- R2: On a tick that the buffer can accept, each live MP whose fast-OR is high in the tick cycle is frozen from the next cycle and tagged with the pre-increment counter value. Hits that arrive in the tick cycle are still captured into its pattern.
- R3: An MP with no hit flags at an accepted tick stays live and keeps collecting hits for a later tick. MPs become frozen only on a tick.
- R4: A hit pulse on a frozen MP is dropped. `lost_cnt_o` rises by one in every cycle in which at least one hit is dropped, and saturates at its all-ones value.
- R5: `bco_cnt_o` is 8 bits wide, advances by one on every tick (accepted or not) and wraps from 255 to 0.
- R6: A tick pushes its timestamp into the scan buffer only if at least one MP freezes on it. Entries are served oldest first.
- R7: For each entry, one header word (`out_valid_o`=1, `out_hdr_o`=1, `out_ts_o`=timestamp) appears before any pattern word of that timestamp.
- R8: While scanning, a strobe that names an MP frozen with the head timestamp produces a pattern word one cycle later (`out_hdr_o`=0, pattern, timestamp, index), and that MP becomes live with all flags clear.
- R9: A strobe outside scanning, or naming an MP that is live or tagged with another timestamp, produces no output word and leaves the MP unchanged.
- R10: A tick that arrives while four entries are pending sets the sticky `ovf_o`, freezes nothing and keeps all hits in place. A later accepted tick freezes those MPs.
- R11: After reset, all flags are clear, no MP is frozen, the counters are 0, `ovf_o` is low and no word is output.
- R12: Once the last MP of the head timestamp is released, the entry is retired and the header of the next pending entry follows within a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | NUM_MP*16 | Pixel hit pulses, MP m at bits m*16 to m*16+15 |
| bco_tick_i | input | 1 | Bunch-crossing tick, one cycle per period |
| rd_strobe_i | input | 1 | Scanner read request |
| rd_idx_i | input | IDX_W | Index of the MP to read |
| fastor_o | output | NUM_MP | Fast-OR of each MP |
| frozen_o | output | NUM_MP | Freeze state of each MP |
| bco_cnt_o | output | 8 | Time counter |
| out_valid_o | output | 1 | Output word valid |
| out_hdr_o | output | 1 | Output word is a timestamp header |
| out_ts_o | output | 8 | Timestamp of the word |
| out_mp_o | output | IDX_W | MP index of a pattern word |
| out_pat_o | output | 16 | Pattern of a pattern word |
| lost_cnt_o | output | LOST_W | Saturating count of cycles with dropped hits |
| ovf_o | output | 1 | Sticky scan-buffer overflow |

## Verification
A wrong tag or a pointer that drifts in the scan buffer shows up at the next header, as a timestamp that is out of order. A stuck state machine shows up as a pending entry whose header never appears. A freeze or release fault shows at `frozen_o` and `fastor_o` in the cycle right after the tick or read that caused it. A pattern that was corrupted or not cleared shows at the next read of that MP. Missed drops or a wrong overflow decision show up as counter drift that never heals, because both `lost_cnt_o` and `ovf_o` only move one way.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
    localparam int MP_PIX = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEADER,
        ST_SCAN,
        ST_RETIRE
    } scan_state_e;
endpackage

// File: rtl/mpf_macro_pixel.sv
module mpf_macro_pixel #(
    parameter int PIX    = 16,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX-1:0]    hit,
    input  logic              freeze_req,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic              release_req,
    output logic [PIX-1:0]    flags,
    output logic              frozen,
    output logic [SLOT_W-1:0] slot,
    output logic              drop
);
    assign drop = frozen && (hit != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= '0;
            frozen <= 1'b0;
            slot   <= '0;
        end else if (release_req) begin
            flags  <= '0;
            frozen <= 1'b0;
        end else if (!frozen) begin
            flags <= flags | hit;
            if (freeze_req && (flags != '0)) begin
                frozen <= 1'b1;
                slot   <= cur_slot;
            end
        end
    end
endmodule

// File: rtl/mpf_ts_fifo.sv
module mpf_ts_fifo #(
    parameter int DEPTH = 4,
    parameter int TS_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [TS_W-1:0]               push_ts,
    input  logic                          pop,
    output logic [TS_W-1:0]               head_ts,
    output logic [$clog2(DEPTH)-1:0]      rd_ptr,
    output logic [$clog2(DEPTH)-1:0]      wr_ptr,
    output logic                          full,
    output logic                          empty
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = SLOT_W + 1;

    logic [TS_W-1:0]  mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign head_ts = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_ptr] <= push_ts;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop && !empty) begin
                rd_ptr <= nxt(rd_ptr);
            end
            cnt <= cnt + CNT_W'(push && !full) - CNT_W'(pop && !empty);
        end
    end
endmodule

// File: rtl/mpf_scan_fsm.sv
module mpf_scan_fsm
    import mpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic remaining,
    output logic hdr_fire,
    output logic scan_active,
    output logic pop
);
    scan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        hdr_fire    = 1'b0;
        scan_active = 1'b0;
        pop         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pending) state_d = ST_HEADER;
            end
            ST_HEADER: begin
                hdr_fire = 1'b1;
                state_d  = ST_SCAN;
            end
            ST_SCAN: begin
                scan_active = 1'b1;
                if (!remaining) state_d = ST_RETIRE;
            end
            ST_RETIRE: begin
                pop     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mp_freeze_ctrl.sv
module mp_freeze_ctrl
    import mpf_pkg::*;
#(
    parameter int NUM_MP  = 8,
    parameter int TS_W    = 8,
    parameter int SB_DEPTH = 4,
    parameter int LOST_W  = 8,
    parameter int IDX_W   = (NUM_MP > 1) ? $clog2(NUM_MP) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_MP*MP_PIX-1:0] hit_i,
    input  logic                     bco_tick_i,
    input  logic                     rd_strobe_i,
    input  logic [IDX_W-1:0]         rd_idx_i,
    output logic [NUM_MP-1:0]        fastor_o,
    output logic [NUM_MP-1:0]        frozen_o,
    output logic [TS_W-1:0]          bco_cnt_o,
    output logic                     out_valid_o,
    output logic                     out_hdr_o,
    output logic [TS_W-1:0]          out_ts_o,
    output logic [IDX_W-1:0]         out_mp_o,
    output logic [MP_PIX-1:0]        out_pat_o,
    output logic [LOST_W-1:0]        lost_cnt_o,
    output logic                     ovf_o
);
    localparam int SLOT_W = $clog2(SB_DEPTH);

    logic [MP_PIX-1:0] flags  [NUM_MP];
    logic [SLOT_W-1:0] slots  [NUM_MP];
    logic [NUM_MP-1:0] drops;
    logic [NUM_MP-1:0] releases;
    logic [NUM_MP-1:0] head_match;

    logic              fifo_full, fifo_empty, accept_tick, any_live_hit, push;
    logic [TS_W-1:0]   head_ts;
    logic [SLOT_W-1:0] rd_ptr, wr_ptr;
    logic              hdr_fire, scan_active, pop, rd_ok;

    assign accept_tick  = bco_tick_i && !fifo_full;
    assign any_live_hit = |(fastor_o & ~frozen_o);
    assign push         = accept_tick && any_live_hit;
    assign rd_ok        = scan_active && rd_strobe_i && head_match[rd_idx_i];

    for (genvar m = 0; m < NUM_MP; m++) begin : g_mp
        mpf_macro_pixel #(.PIX(MP_PIX), .SLOT_W(SLOT_W)) u_mp (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit_i[m*MP_PIX +: MP_PIX]),
            .freeze_req (accept_tick),
            .cur_slot   (wr_ptr),
            .release_req(releases[m]),
            .flags      (flags[m]),
            .frozen     (frozen_o[m]),
            .slot       (slots[m]),
            .drop       (drops[m])
        );
        assign fastor_o[m]   = |flags[m];
        assign head_match[m] = frozen_o[m] && (slots[m] == rd_ptr);
        assign releases[m]   = rd_ok && (rd_idx_i == IDX_W'(m));
    end

    mpf_ts_fifo #(.DEPTH(SB_DEPTH), .TS_W(TS_W)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .push_ts(bco_cnt_o),
        .pop    (pop),
        .head_ts(head_ts),
        .rd_ptr (rd_ptr),
        .wr_ptr (wr_ptr),
        .full   (fifo_full),
        .empty  (fifo_empty)
    );

    mpf_scan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (!fifo_empty),
        .remaining  (|head_match),
        .hdr_fire   (hdr_fire),
        .scan_active(scan_active),
        .pop        (pop)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bco_cnt_o  <= '0;
            lost_cnt_o <= '0;
            ovf_o      <= 1'b0;
        end else begin
            if (bco_tick_i) bco_cnt_o <= bco_cnt_o + 1'b1;
            if ((drops != '0) && (lost_cnt_o != '1)) lost_cnt_o <= lost_cnt_o + 1'b1;
            if (bco_tick_i && fifo_full) ovf_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_hdr_o   <= 1'b0;
            out_ts_o    <= '0;
            out_mp_o    <= '0;
            out_pat_o   <= '0;
        end else begin
            out_valid_o <= hdr_fire || rd_ok;
            out_hdr_o   <= hdr_fire;
            out_ts_o    <= head_ts;
            out_mp_o    <= rd_idx_i;
            out_pat_o   <= rd_ok ? flags[rd_idx_i] : '0;
        end
    end
endmodule

// File: rtl/mp_freeze_ctrl_chk.sv
module mp_freeze_ctrl_chk #(
    parameter int NUM_MP = 8,
    parameter int TS_W   = 8,
    parameter int LOST_W = 8,
    parameter int PIX    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bco_tick_i,
    input logic [NUM_MP-1:0] frozen_o,
    input logic [NUM_MP-1:0] fastor_o,
    input logic [TS_W-1:0]   bco_cnt_o,
    input logic              out_valid_o,
    input logic              out_hdr_o,
    input logic [PIX-1:0]    out_pat_o,
    input logic [LOST_W-1:0] lost_cnt_o,
    input logic              ovf_o
);
    assert_freeze_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bco_tick_i |=> ((frozen_o & ~$past(frozen_o)) == '0));

    assert_frozen_has_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o & ~fastor_o) == '0);

    assert_lost_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lost_cnt_o >= $past(lost_cnt_o));

    assert_bco_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bco_tick_i |=> bco_cnt_o == $past(bco_cnt_o) + 1'b1);

    assert_bco_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bco_tick_i |=> $stable(bco_cnt_o));

    assert_pattern_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_hdr_o) |-> (out_pat_o != '0));

    assert_hdr_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_hdr_o |-> out_valid_o);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
endmodule

bind mp_freeze_ctrl mp_freeze_ctrl_chk #(
    .NUM_MP(NUM_MP), .TS_W(TS_W), .LOST_W(LOST_W), .PIX(mpf_pkg::MP_PIX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bco_tick_i (bco_tick_i),
    .frozen_o   (frozen_o),
    .fastor_o   (fastor_o),
    .bco_cnt_o  (bco_cnt_o),
    .out_valid_o(out_valid_o),
    .out_hdr_o  (out_hdr_o),
    .out_pat_o  (out_pat_o),
    .lost_cnt_o (lost_cnt_o),
    .ovf_o      (ovf_o)
);

// File: tb/sim_mp_freeze_ctrl.sv
module sim_mp_freeze_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NUM  = 8;
    localparam int PIX  = 16;
    localparam int IW   = 3;
    localparam int DEPTH = 4;
    localparam int LOST_MAX = 255;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM*PIX-1:0] hit = '0;
    logic              tick = 1'b0;
    logic              rd = 1'b0;
    logic [IW-1:0]     rd_idx = '0;

    logic [NUM-1:0] fastor, frozen;
    logic [7:0]     bco, ots, lost;
    logic           ovalid, ohdr, ovf;
    logic [IW-1:0]  omp;
    logic [PIX-1:0] opat;

    mp_freeze_ctrl #(.NUM_MP(NUM)) u0 (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .bco_tick_i(tick),
        .rd_strobe_i(rd), .rd_idx_i(rd_idx), .fastor_o(fastor), .frozen_o(frozen),
        .bco_cnt_o(bco), .out_valid_o(ovalid), .out_hdr_o(ohdr), .out_ts_o(ots),
        .out_mp_o(omp), .out_pat_o(opat), .lost_cnt_o(lost), .ovf_o(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    logic [PIX-1:0] m_flags [NUM];
    logic           m_frz   [NUM];
    logic [7:0]     m_tag   [NUM];
    logic [7:0]     q [DEPTH];
    int             q_cnt = 0;
    logic [7:0]     m_bco = '0;
    int             m_lost = 0;
    logic           m_ovf = 1'b0;
    logic           exp_valid = 1'b0;
    logic [PIX-1:0] exp_pat = '0;
    logic [7:0]     exp_ts = '0;
    logic [IW-1:0]  exp_mp = '0;
    logic           in_scan = 1'b0;
    int             pop_dly = 0;
    int             wait_hdr = 0;
    int             ovf_seen = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit head_left();
        for (int m = 0; m < NUM; m++)
            if (m_frz[m] && q_cnt > 0 && m_tag[m] == q[0]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_update();
        logic [PIX-1:0] pre_f [NUM];
        logic           pre_z [NUM];
        bit full, any_drop, any_frz;
        full = (q_cnt == DEPTH);
        any_drop = 0;
        exp_valid = 1'b0;
        for (int m = 0; m < NUM; m++) begin
            pre_f[m] = m_flags[m];
            pre_z[m] = m_frz[m];
            if (pre_z[m]) begin
                if (hit[m*PIX +: PIX] != '0) any_drop = 1;
            end else begin
                m_flags[m] = m_flags[m] | hit[m*PIX +: PIX];
            end
        end
        if (pop_dly > 0) begin
            pop_dly--;
            if (pop_dly == 0) begin
                for (int i = 0; i < DEPTH-1; i++) q[i] = q[i+1];
                q_cnt--;
            end
        end
        if (rd && in_scan && pre_z[rd_idx] && m_tag[rd_idx] == q[0]) begin
            exp_valid = 1'b1;
            exp_pat = pre_f[rd_idx];
            exp_ts = q[0];
            exp_mp = rd_idx;
            m_flags[rd_idx] = '0;
            m_frz[rd_idx] = 1'b0;
            if (!head_left()) begin
                in_scan = 1'b0;
                pop_dly = 2;
            end
        end
        if (tick) begin
            if (full) begin
                m_ovf = 1'b1;
                ovf_seen++;
            end else begin
                any_frz = 0;
                for (int m = 0; m < NUM; m++)
                    if (!pre_z[m] && pre_f[m] != '0) begin
                        m_frz[m] = 1'b1;
                        m_tag[m] = m_bco;
                        any_frz = 1;
                    end
                if (any_frz) begin
                    q[q_cnt] = m_bco;
                    q_cnt++;
                end
            end
            m_bco = m_bco + 8'd1;
        end
        if (any_drop && m_lost < LOST_MAX) m_lost++;
    endtask

    task automatic compare();
        for (int m = 0; m < NUM; m++) begin
            chk("R1 fast-OR", 32'(fastor[m]), 32'(m_flags[m] != '0));
            chk(m_frz[m] ? "R2 frozen" : "R3 stays live", 32'(frozen[m]), 32'(m_frz[m]));
        end
        chk("R5 time counter", 32'(bco), 32'(m_bco));
        chk("R4 lost counter", 32'(lost), 32'(m_lost));
        chk("R10 overflow flag", 32'(ovf), 32'(m_ovf));
        if (ovalid && ohdr) begin
            chk("R7 header while idle", 32'(in_scan), 32'd0);
            chk("R6 header pending", 32'(q_cnt > 0), 32'd1);
            chk("R6 header timestamp order", 32'(ots), 32'(q[0]));
            in_scan = 1'b1;
        end else if (ovalid) begin
            chk("R8 read accepted", 32'(exp_valid), 32'd1);
            chk("R8 pattern", 32'(opat), 32'(exp_pat));
            chk("R8 timestamp", 32'(ots), 32'(exp_ts));
            chk("R8 index", 32'(omp), 32'(exp_mp));
        end else begin
            chk("R9 no output word", 32'(exp_valid), 32'd0);
        end
        if (q_cnt > 0 && !in_scan) wait_hdr++;
        else wait_hdr = 0;
        if (wait_hdr == 12) chk("R12 next header served", 32'd0, 32'd1);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic set_hits(input int prob);
        hit = '0;
        for (int m = 0; m < NUM; m++)
            if ($urandom_range(0, 99) < prob)
                hit[m*PIX + $urandom_range(0, PIX-1)] = 1'b1;
    endtask

    task automatic pick_read(input int prob);
        int cand [NUM];
        int nc;
        rd = 1'b0;
        nc = 0;
        if (in_scan)
            for (int m = 0; m < NUM; m++)
                if (m_frz[m] && m_tag[m] == q[0]) begin
                    cand[nc] = m;
                    nc++;
                end
        if (nc > 0 && $urandom_range(0, 99) < prob) begin
            rd = 1'b1;
            rd_idx = IW'(cand[$urandom_range(0, nc-1)]);
        end else if ($urandom_range(0, 9) == 0) begin
            rd = 1'b1;
            rd_idx = IW'($urandom_range(0, NUM-1));
        end
    endtask

    initial begin
        for (int i = 0; i < NUM; i++) begin
            m_flags[i] = '0; m_frz[i] = 1'b0; m_tag[i] = '0;
        end
        for (int i = 0; i < DEPTH; i++) q[i] = '0;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk("watchdog expired", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R11 reset fastor", 32'(fastor), 32'd0);
        chk("R11 reset frozen", 32'(frozen), 32'd0);
        chk("R11 reset counters", 32'({bco, lost}), 32'd0);
        chk("R11 reset flags", 32'({ovalid, ovf}), 32'd0);
        rst_n = 1'b1;

        // directed: MP0 gets a hit, then a tick arrives together with a first hit on MP1
        hit = '0; hit[3] = 1'b1; step();
        hit = '0; hit[PIX+5] = 1'b1; tick = 1'b1; step();
        tick = 1'b0; hit = '0;
        // read of a frozen MP before the header: must be ignored (R9)
        rd = 1'b1; rd_idx = '0; step();
        rd = 1'b0;
        // hit on frozen MP0 is dropped (R4)
        hit[0] = 1'b1; step(); hit = '0;
        for (int c = 0; c < 10; c++) begin
            pick_read(100);
            step();
        end
        rd = 1'b0;

        // random phase with a brisk scanner, then a slow one to fill the buffer
        for (int c = 0; c < 9000; c++) begin
            set_hits(c < 4500 ? 15 : 25);
            tick = ($urandom_range(0, 11) == 0);
            pick_read(c < 4500 ? 70 : 6);
            step();
        end
        // drain
        hit = '0; tick = 1'b0;
        for (int c = 0; c < 200; c++) begin
            pick_read(100);
            step();
        end
        chk("R10 overflow exercised", 32'(ovf_seen > 0), 32'd1);
        chk("R12 all entries drained", 32'(q_cnt), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule